// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the division ratio of a PLL feedback divider once per divider cycle. The integer and fractional settings both come from one 32-bit control word. A third-order noise-shaping modulator dithers the fractional setting over a modulus of 2^15. At every divider-cycle boundary the block adds the modulator's signed correction to the programmed integer. It clamps the sum to the legal range and registers the result as the ratio for the next divider cycle.

The block contains a behavioural pulse-swallow counter that uses a dual-modulus prescaler. It runs on the clock that stands in for the oscillator and emits one feedback pulse per divider cycle, so the output pulse spacing follows the modulated ratio. A control word written through the load strobe is held aside. It replaces the running settings only at the next divider-cycle boundary, and it restarts the modulator from a cleared state at that boundary.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While reset is high, `div_ratio` is 23 and `fb_pulse` is 0. After reset is released, the first `fb_pulse` appears 23 clocks later.
- R2: The integer setting I is taken from control-word bits [26:19] and the fraction F from bits [18:4]. Bits [31:27] and [3:0] have no effect on the ratio sequence.
- R3: At each divider-cycle boundary the new ratio is clamp(I + y). Here y = c1 + c2 - c2' + c3 - 2*c3' + c3''. c1, c2 and c3 are the carries of three cascaded 15-bit accumulators: the first adds F, and each later one adds the previous accumulator's new sum. A prime marks the value one boundary earlier.
- R4: The correction y stays between -3 and +4 inclusive.
- R5: The ratio never goes below 23 or above 255.
- R6: `fb_pulse` is high for one clock per divider cycle. Two consecutive pulses are exactly as many clocks apart as the `div_ratio` shown during the first of them.
- R7: `div_ratio` changes only on the clock where `fb_pulse` is high. A written word has no effect before the next boundary.
- R8: Taking a new word clears all accumulators and carry history. The first ratio after a load is therefore clamp(I).
- R9: A write on the same clock as a boundary does not apply at that boundary. It applies at the following one.
- R10: Over K consecutive divider cycles without clamping, the sum of (ratio - I) differs from K*F/32768 by less than 3.
- R11: With F = 0 the ratio stays at clamp(I).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider clock (stands in for the oscillator output) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-clock strobe that captures `cfg_word` |
| cfg_word | input | 32 | Control word holding the integer and fractional fields |
| div_ratio | output | 8 | Divide ratio of the divider cycle now running |
| fb_pulse | output | 1 | One-clock feedback pulse that starts each divider cycle |

## Verification
The assertions assume that the minimum ratio is at least P*(P-1) for prescaler modulus P, so every ratio splits into a legal swallow count and main count. They also assume that reset is held for at least one edge before checking begins. The bench keeps to these limits by using the default prescaler and ratio floor. Its integer settings cover values below the floor, exactly at the floor, at the ceiling, and in the unclamped middle, and it times one write to land exactly on a boundary.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Order of the noise-shaping cascade; the step range -3..+4 follows from it
  localparam int MASH_STAGES = 3;
  localparam int STEP_W      = 4;

  typedef logic signed [STEP_W-1:0] mash_step_t;
endpackage

// File: rtl/fracn_cfg_hold.sv
module fracn_cfg_hold #(
  parameter int CW_W     = 32,
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 15,
  parameter int INT_LSB  = 19,
  parameter int FRAC_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CW_W-1:0]   cfg_word,
  input  logic              boundary,
  output logic              reload,
  output logic [INT_W-1:0]  eff_int,
  output logic [FRAC_W-1:0] eff_frac
);
  logic [INT_W-1:0]  pend_int_q, act_int_q;
  logic [FRAC_W-1:0] pend_frac_q, act_frac_q;
  logic              pend_vld_q;
  logic              unused_word_par;

  // Fields other than the two divider fields are ignored here
  assign unused_word_par = ^cfg_word;

  assign reload   = boundary & pend_vld_q;
  assign eff_int  = reload ? pend_int_q  : act_int_q;
  assign eff_frac = reload ? pend_frac_q : act_frac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_int_q  <= '0;
      pend_frac_q <= '0;
      pend_vld_q  <= 1'b0;
      act_int_q   <= '0;
      act_frac_q  <= '0;
    end else begin
      if (reload) begin
        act_int_q  <= pend_int_q;
        act_frac_q <= pend_frac_q;
      end
      // A fresh write wins over the boundary consuming the held word
      if (cfg_wr) begin
        pend_int_q  <= cfg_word[INT_LSB +: INT_W];
        pend_frac_q <= cfg_word[FRAC_LSB +: FRAC_W];
        pend_vld_q  <= 1'b1;
      end else if (boundary) begin
        pend_vld_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fracn_mash3.sv
module fracn_mash3
  import fracn_pkg::*;
#(
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              clr,
  input  logic [FRAC_W-1:0] frac,
  output mash_step_t        y_next
);
  logic [FRAC_W-1:0]      acc_q [MASH_STAGES];
  logic [FRAC_W-1:0]      acc_n [MASH_STAGES];
  logic [MASH_STAGES-1:0] cy;
  logic                   c2_d_q, c3_d_q, c3_dd_q;
  logic                   c2_d, c3_d, c3_dd;
  logic [STEP_W-1:0]      y_raw;

  for (genvar g = 0; g < MASH_STAGES; g++) begin : g_stage
    logic [FRAC_W-1:0] base;
    logic [FRAC_W-1:0] addend;
    logic [FRAC_W:0]   sum;
    assign base = clr ? '0 : acc_q[g];
    if (g == 0) begin : g_in
      assign addend = frac;
    end else begin : g_chain
      assign addend = g_stage[g-1].sum[FRAC_W-1:0];
    end
    assign sum      = {1'b0, base} + {1'b0, addend};
    assign acc_n[g] = sum[FRAC_W-1:0];
    assign cy[g]    = sum[FRAC_W];
  end

  assign c2_d  = clr ? 1'b0 : c2_d_q;
  assign c3_d  = clr ? 1'b0 : c3_d_q;
  assign c3_dd = clr ? 1'b0 : c3_dd_q;

  // c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3, in 4-bit two's complement
  assign y_raw = STEP_W'(cy[0]) + STEP_W'(cy[1]) - STEP_W'(c2_d)
               + STEP_W'(cy[2]) - STEP_W'({c3_d, 1'b0}) + STEP_W'(c3_dd);
  assign y_next = $signed(y_raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < MASH_STAGES; k++) acc_q[k] <= '0;
      c2_d_q  <= 1'b0;
      c3_d_q  <= 1'b0;
      c3_dd_q <= 1'b0;
    end else if (step) begin
      for (int k = 0; k < MASH_STAGES; k++) acc_q[k] <= acc_n[k];
      c2_d_q  <= cy[1];
      c3_d_q  <= cy[2];
      c3_dd_q <= c3_d;
    end
  end
endmodule

// File: rtl/fracn_swallow_cnt.sv
module fracn_swallow_cnt #(
  parameter int N_W        = 8,
  parameter int PRESC_LOG2 = 2,
  parameter int N_MIN      = 23
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] ratio_next,
  output logic           terminal
);
  localparam int PRESC = 1 << PRESC_LOG2;
  localparam int MN_W  = N_W - PRESC_LOG2;
  localparam int PRE_W = PRESC_LOG2 + 1;
  localparam logic [N_W-1:0]   N_MIN_V = N_W'(N_MIN);
  localparam logic [PRE_W-1:0] PRE_LONG  = PRE_W'(PRESC);
  localparam logic [PRE_W-1:0] PRE_SHORT = PRE_W'(PRESC - 1);

  logic [PRE_W-1:0]      pre_q;
  logic [PRESC_LOG2-1:0] sw_q, sw_dec;
  logic [MN_W-1:0]       mn_q;
  logic                  pre_wrap;

  // Split of the next ratio: main count above, swallow count below
  logic [MN_W-1:0]       ld_mn;
  logic [PRESC_LOG2-1:0] ld_sw;
  logic [PRE_W-1:0]      ld_pre;

  assign ld_mn  = ratio_next[N_W-1:PRESC_LOG2];
  assign ld_sw  = ratio_next[PRESC_LOG2-1:0];
  assign ld_pre = (ld_sw != '0) ? PRE_LONG : PRE_SHORT;

  assign pre_wrap = (pre_q == '0);
  assign terminal = pre_wrap && (mn_q == MN_W'(1));
  assign sw_dec   = (sw_q != '0) ? sw_q - 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mn_q  <= N_MIN_V[N_W-1:PRESC_LOG2];
      sw_q  <= N_MIN_V[PRESC_LOG2-1:0];
      pre_q <= (N_MIN_V[PRESC_LOG2-1:0] != '0) ? PRE_LONG : PRE_SHORT;
    end else if (terminal) begin
      mn_q  <= ld_mn;
      sw_q  <= ld_sw;
      pre_q <= ld_pre;
    end else if (pre_wrap) begin
      // Prescaler runs at modulus P+1 while swallow cycles remain
      mn_q  <= mn_q - 1'b1;
      sw_q  <= sw_dec;
      pre_q <= (sw_dec != '0) ? PRE_LONG : PRE_SHORT;
    end else begin
      pre_q <= pre_q - 1'b1;
    end
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int CW_W       = 32,
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 15,
  parameter int INT_LSB    = 19,
  parameter int FRAC_LSB   = 4,
  parameter int N_MIN      = 23,
  parameter int PRESC_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CW_W-1:0]  cfg_word,
  output logic [INT_W-1:0] div_ratio,
  output logic             fb_pulse
);
  localparam int N_MAX = (1 << INT_W) - 1;
  localparam int SUM_W = INT_W + 2;

  logic              boundary;
  logic              reload;
  logic [INT_W-1:0]  eff_int;
  logic [FRAC_W-1:0] eff_frac;
  mash_step_t        mash_y;
  logic signed [SUM_W-1:0] raw_sum;
  logic [INT_W-1:0]  ratio_next;

  fracn_cfg_hold #(
    .CW_W(CW_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
    .INT_LSB(INT_LSB), .FRAC_LSB(FRAC_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .boundary(boundary), .reload(reload),
    .eff_int(eff_int), .eff_frac(eff_frac)
  );

  fracn_mash3 #(.FRAC_W(FRAC_W)) u_mash (
    .clk(clk), .rst(rst), .step(boundary), .clr(reload),
    .frac(eff_frac), .y_next(mash_y)
  );

  fracn_swallow_cnt #(
    .N_W(INT_W), .PRESC_LOG2(PRESC_LOG2), .N_MIN(N_MIN)
  ) u_cnt (
    .clk(clk), .rst(rst), .ratio_next(ratio_next), .terminal(boundary)
  );

  always_comb begin
    raw_sum = $signed({2'b00, eff_int})
            + $signed({{(SUM_W-STEP_W){mash_y[STEP_W-1]}}, mash_y});
    if (raw_sum < $signed(SUM_W'(N_MIN)))
      ratio_next = INT_W'(N_MIN);
    else if (raw_sum > $signed(SUM_W'(N_MAX)))
      ratio_next = INT_W'(N_MAX);
    else
      ratio_next = raw_sum[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_ratio <= INT_W'(N_MIN);
      fb_pulse  <= 1'b0;
    end else begin
      fb_pulse <= boundary;
      if (boundary) div_ratio <= ratio_next;
    end
  end
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
module fracn_div_ctrl_chk
  import fracn_pkg::*;
#(
  parameter int INT_W = 8,
  parameter int N_MIN = 23
) (
  input logic             clk,
  input logic             rst,
  input logic             fb_pulse,
  input logic [INT_W-1:0] div_ratio,
  input mash_step_t       mash_y,
  input logic             boundary
);
  logic [INT_W:0]   gap_q;
  logic [INT_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      held_q <= INT_W'(N_MIN);
    end else if (fb_pulse) begin
      gap_q  <= (INT_W+1)'(1);
      held_q <= div_ratio;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R5
  ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
    div_ratio >= INT_W'(N_MIN));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |-> $stable(div_ratio));

  // R6
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> gap_q == {1'b0, held_q});

  // R6
  pulse_early_chk: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |-> gap_q < {1'b0, held_q});

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    boundary |-> (mash_y >= -4'sd3) && (mash_y <= 4'sd4));
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk #(.INT_W(INT_W), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst(rst), .fb_pulse(fb_pulse), .div_ratio(div_ratio),
  .mash_y(mash_y), .boundary(boundary)
);

// File: tb/fracn_div_ctrl_tb.sv
module fracn_div_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MOD = 32768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [7:0]  div_ratio;
  logic        fb_pulse;

  fracn_div_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .div_ratio(div_ratio), .fb_pulse(fb_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  // reference model state
  int a1 = 0, a2 = 0, a3 = 0, d2 = 0, d3 = 0, d33 = 0;
  int act_i = 0, act_f = 0, pend = 0, pend_i = 0, pend_f = 0;
  int exp_ratio = 23, gap = 0, pulses = 0, last_gap = 0, last_ratio = 23;
  int avg_on = 0, avg_k = 0;
  longint avg_sum = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampn(input int v);
    return (v < 23) ? 23 : ((v > 255) ? 255 : v);
  endfunction

  function automatic int mstep(input int f);
    int c1, c2, c3, y;
    a1 += f; c1 = (a1 >= MOD) ? 1 : 0; if (c1 != 0) a1 -= MOD;
    a2 += a1; c2 = (a2 >= MOD) ? 1 : 0; if (c2 != 0) a2 -= MOD;
    a3 += a2; c3 = (a3 >= MOD) ? 1 : 0; if (c3 != 0) a3 -= MOD;
    y = c1 + c2 - d2 + c3 - 2*d3 + d33;
    d33 = d3; d3 = c3; d2 = c2;
    return y;
  endfunction

  function automatic logic [31:0] mk(input int i, input int f, input logic [8:0] junk);
    return {junk[8:4], i[7:0], f[14:0], junk[3:0]};
  endfunction

  task automatic on_pulse();
    int y, dr, first;
    dr = int'(div_ratio);
    chk(gap == exp_ratio, "R6 pulse spacing", gap, exp_ratio);
    last_gap = gap;
    gap = 0;
    pulses++;
    first = pend;
    if (pend != 0) begin
      act_i = pend_i; act_f = pend_f; pend = 0;
      a1 = 0; a2 = 0; a3 = 0; d2 = 0; d3 = 0; d33 = 0;
    end
    y = mstep(act_f);
    exp_ratio = clampn(act_i + y);
    chk(dr == exp_ratio, "R3 ratio", dr, exp_ratio);
    chk(dr >= 23 && dr <= 255, "R5 range", dr, exp_ratio);
    if (first != 0) chk(dr == clampn(act_i), "R8 first ratio after load", dr, clampn(act_i));
    if (act_f == 0) chk(dr == clampn(act_i), "R11 zero fraction", dr, clampn(act_i));
    if (act_i >= 26 && act_i <= 251)
      chk((dr - act_i) >= -3 && (dr - act_i) <= 4, "R4 step range", dr - act_i, 0);
    if (avg_on != 0) begin
      avg_sum += longint'(dr - act_i);
      avg_k++;
    end
    last_ratio = dr;
  endtask

  task automatic tick(input logic wr, input logic [31:0] w);
    cfg_wr = wr;
    cfg_word = w;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    gap++;
    if (fb_pulse) on_pulse();
    else begin
      chk(int'(div_ratio) == exp_ratio, "R7 ratio held", int'(div_ratio), exp_ratio);
      chk(gap < exp_ratio, "R6 no late pulse", gap, exp_ratio);
    end
    if (wr) begin
      pend = 1; pend_i = int'(w[26:19]); pend_f = int'(w[18:4]);
    end
  endtask

  task automatic run_pulses(input int n);
    int target;
    target = pulses + n;
    while (pulses < target) tick(1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog: actual %0d pulses expected completion", pulses);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    longint err;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(int'(div_ratio) == 23, "R1 reset ratio", int'(div_ratio), 23);
    chk(fb_pulse == 1'b0, "R1 reset pulse", int'(fb_pulse), 0);
    rst = 1'b0;
    run_pulses(1);
    chk(last_gap == 23, "R1 first pulse delay", last_gap, 23);
    run_pulses(2);

    // plain integer, written mid-cycle (R7 hold checked every clock)
    tick(1'b1, mk(60, 0, 9'h0));
    run_pulses(4);

    // R2: junk in the non-divider bits
    tick(1'b1, mk(77, 0, 9'h1BF));
    run_pulses(4);
    chk(last_ratio == 77, "R2 field decode", last_ratio, 77);

    // modulated sequences
    tick(1'b1, mk(100, 3, 9'h0));
    run_pulses(40);
    tick(1'b1, mk(33, 32767, 9'h0));
    run_pulses(40);
    // R8: same word again restarts the modulator
    tick(1'b1, mk(33, 32767, 9'h0));
    run_pulses(10);

    // R5 clamp at both ends
    tick(1'b1, mk(23, 20000, 9'h0));
    run_pulses(50);
    tick(1'b1, mk(255, 30000, 9'h0));
    run_pulses(30);
    chk(last_ratio <= 255, "R5 ceiling", last_ratio, 255);
    tick(1'b1, mk(10, 5000, 9'h0));
    run_pulses(20);
    chk(last_ratio == 23, "R5 floor", last_ratio, 23);

    // R9: write landing on the boundary clock
    tick(1'b1, mk(50, 0, 9'h0));
    run_pulses(3);
    while (gap != exp_ratio - 1) tick(1'b0, '0);
    tick(1'b1, mk(90, 0, 9'h0));
    chk(last_ratio == 50, "R9 coincident write deferred", last_ratio, 50);
    run_pulses(1);
    chk(last_ratio == 90, "R9 applied next boundary", last_ratio, 90);

    // R10 long-run average
    tick(1'b1, mk(40, 12345, 9'h0));
    run_pulses(1);
    avg_on = 1;
    run_pulses(1024);
    avg_on = 0;
    err = avg_sum * MOD - longint'(avg_k) * 12345;
    if (err < 0) err = -err;
    chk(err < 3 * MOD, "R10 average", int'(avg_sum), int'((longint'(avg_k) * 12345) / MOD));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule